// File: doc/BRIEF.md
# Dual Masked Calendar Alarm

This block holds two independent alarm units that watch the running time and calendar of a clock. Each unit stores a target value for six fields: second, minute, hour, day of week, date and month. Each field carries its own match enable, so an alarm can be aimed at one exact moment, or at every moment that agrees on a chosen subset of fields. The comparison runs only on the one-second tick that the timekeeper supplies. A hit sets a sticky flag for that unit. In one-shot mode the unit disarms itself when it fires. In repeat mode it stays armed and keeps producing periodic events, for example once a minute when only the seconds field is enabled.

The flags can be polled, or they can pull an open-drain output low when the unit's interrupt enable is set. That output pin is shared with a square-wave frequency output, and a select input picks which one owns the pin. The host programs the units through a simple write strobe. Each field word carries its enable in the top bit. A control word holds the arm, repeat and interrupt-enable bits.

Top module: `dual_alarm`

## Requirements
- R1: After synchronous reset, every flag is 0, every unit is disarmed, all field enables are 0, and `pin_drive_low` is 0 (the pin floats).
- R2: A unit evaluates its match only in a cycle where `tick` is 1. Its flag rises at the clock edge that samples that tick and never rises without one.
- R3: A unit fires only when it is armed and every enabled field equals the live field. Disabled fields take no part in the match. Field words use `cfg_addr` 0 to 5 for second, minute, hour, day of week, date and month. `cfg_wdata[FW]` is the field enable and `cfg_wdata[FW-1:0]` is the value. `now_time` carries field i at bits [i*FW +: FW].
- R4: A unit whose six field enables are all 0 never fires, even while it is armed.
- R5: Without repeat, the unit's arm bit (`armed`) clears at the edge where it fires, and later matching ticks do not fire it. A control write in the same cycle takes precedence over this self-disarm.
- R6: With repeat set, the unit stays armed after firing and fires again on every later matching tick.
- R7: A flag stays set until a one-cycle pulse on its `flag_clr` bit clears it. If a fire and a clear occur in the same cycle, the flag stays set.
- R8: With `pin_sel` = 0, `pin_drive_low` is 1 exactly one cycle after some unit has both its flag and its interrupt enable set, and is 0 otherwise. A unit whose interrupt enable is 0 is polled only: its flag never moves the pin.
- R9: With `pin_sel` = 1, `pin_drive_low` equals the inverse of `freq_in` one cycle later, and the flags have no effect on it.
- R10: The control word is written at `cfg_addr` 7, with bit 0 = arm, bit 1 = repeat and bit 2 = interrupt enable. The target unit is `cfg_unit`. A write to one unit leaves the other unit's configuration and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| now_time | input | 6*FW | Live second, minute, hour, day of week, date, month |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | UW | Alarm unit selected by the write |
| cfg_addr | input | 3 | 0-5 field word, 7 control word |
| cfg_wdata | input | FW+1 | Write data |
| flag_clr | input | NUM_ALARMS | Per-unit flag clear pulse |
| pin_sel | input | 1 | 0 interrupt, 1 frequency output on the pin |
| freq_in | input | 1 | Square wave routed to the pin in frequency mode |
| flags | output | NUM_ALARMS | Sticky alarm flags |
| armed | output | NUM_ALARMS | Per-unit arm bit |
| pin_drive_low | output | 1 | 1 pulls the open-drain pin low, 0 lets it float |

## Verification
The units are driven with matching values held without a tick, which separates tick gating from pure comparison. A mismatch on an enabled field is contrasted with a mismatch on a disabled field, and a six-field match that differs only in month shows that each enable truly gates its field. Ticks that repeat after a fire tell one-shot from repeat mode. A simultaneous clear and fire settles which of the two wins. The pin is exercised with interrupt enable on and off and then in frequency mode while a flag is set, which isolates the polled, interrupt and clock-output behaviours.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam logic [2:0] CTRL_ADDR = 3'd7;
endpackage

// File: rtl/alarm_unit.sv
module alarm_unit
  import alm_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic [NUM_FIELDS*FW-1:0] now_time,
  input  logic                     we,
  input  logic [2:0]               addr,
  input  logic [FW:0]              wdata,
  input  logic                     clr,
  output logic                     flag,
  output logic                     armed,
  output logic                     irq_en
);
  logic [NUM_FIELDS-1:0] hit;
  logic [NUM_FIELDS-1:0] fen;
  logic                  rep_q;
  logic                  fire;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [FW-1:0] val_q;
    logic          en_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
        en_q  <= 1'b0;
      end else if (we && addr == 3'(i)) begin
        val_q <= wdata[FW-1:0];
        en_q  <= wdata[FW];
      end
    end
    assign fen[i] = en_q;
    assign hit[i] = !en_q || (val_q == now_time[i*FW +: FW]);
  end

  // evaluated only on the one-second tick
  assign fire = tick && armed && (&hit) && (|fen);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      armed  <= 1'b0;
      rep_q  <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (fire)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (we && addr == CTRL_ADDR) begin
        armed  <= wdata[0];
        rep_q  <= wdata[1];
        irq_en <= wdata[2];
      end else if (fire && !rep_q) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alarm_pin.sv
module alarm_pin #(
  parameter int NA = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NA-1:0] flags,
  input  logic [NA-1:0] ie,
  input  logic          pin_sel,
  input  logic          freq_in,
  output logic          drive_low
);
  always_ff @(posedge clk) begin
    if (rst) drive_low <= 1'b0;
    else     drive_low <= pin_sel ? !freq_in : |(flags & ie);
  end
endmodule

// File: rtl/dual_alarm.sv
module dual_alarm
  import alm_pkg::*;
#(
  parameter int FW         = 8,
  parameter int NUM_ALARMS = 2,
  localparam int UW = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic [NUM_FIELDS*FW-1:0] now_time,
  input  logic                     cfg_we,
  input  logic [UW-1:0]            cfg_unit,
  input  logic [2:0]               cfg_addr,
  input  logic [FW:0]              cfg_wdata,
  input  logic [NUM_ALARMS-1:0]    flag_clr,
  input  logic                     pin_sel,
  input  logic                     freq_in,
  output logic [NUM_ALARMS-1:0]    flags,
  output logic [NUM_ALARMS-1:0]    armed,
  output logic                     pin_drive_low
);
  logic [NUM_ALARMS-1:0] ie;

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_unit
    alarm_unit #(.FW(FW)) u_alarm (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .now_time (now_time),
      .we       (cfg_we && cfg_unit == UW'(k)),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .clr      (flag_clr[k]),
      .flag     (flags[k]),
      .armed    (armed[k]),
      .irq_en   (ie[k])
    );
  end

  alarm_pin #(.NA(NUM_ALARMS)) u_pin (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .ie        (ie),
    .pin_sel   (pin_sel),
    .freq_in   (freq_in),
    .drive_low (pin_drive_low)
  );
endmodule

// File: rtl/dual_alarm_chk.sv
module dual_alarm_chk #(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic                  cfg_we,
  input logic [NUM_ALARMS-1:0] flag_clr,
  input logic                  pin_sel,
  input logic                  freq_in,
  input logic [NUM_ALARMS-1:0] flags,
  input logic [NUM_ALARMS-1:0] armed,
  input logic                  pin_drive_low
);
  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_chk
    // R2
    a_r2_flag_needs_tick: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(flags[k])) |-> $past(tick));
    // R7
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(flags[k])) |-> $past(flag_clr[k]));
    // R5
    a_r5_disarm_cause: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(armed[k])) |-> ($past(tick) || $past(cfg_we)));
  end

  // R8
  a_r8_pin_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pin_sel) && $past(flags) == '0) |-> !pin_drive_low);
  // R9
  a_r9_freq_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_sel)) |-> (pin_drive_low == !$past(freq_in)));
endmodule

bind dual_alarm dual_alarm_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick          (tick),
  .cfg_we        (cfg_we),
  .flag_clr      (flag_clr),
  .pin_sel       (pin_sel),
  .freq_in       (freq_in),
  .flags         (flags),
  .armed         (armed),
  .pin_drive_low (pin_drive_low)
);

// File: tb/dual_alarm_tb.sv
`timescale 1ns/1ps
module dual_alarm_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  tf [6];
  logic [47:0] now_time;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_unit = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [8:0]  cfg_wdata = 9'd0;
  logic [1:0]  flag_clr = 2'b00;
  logic        pin_sel = 1'b0;
  logic        freq_in = 1'b1;
  logic [1:0]  flags;
  logic [1:0]  armed;
  logic        pin_drive_low;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign now_time = {tf[5], tf[4], tf[3], tf[2], tf[1], tf[0]};

  dual_alarm u_dut (
    .clk(clk), .rst(rst), .tick(tick), .now_time(now_time),
    .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .pin_sel(pin_sel),
    .freq_in(freq_in), .flags(flags), .armed(armed),
    .pin_drive_low(pin_drive_low)
  );

  // behavioural reference model
  int mval [2][6];
  bit men  [2][6];
  bit marm [2];
  bit mrep [2];
  bit mie  [2];
  bit mflag[2];
  bit mpin;

  always @(posedge clk) begin
    bit pin_n;
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        marm[k] = 0; mrep[k] = 0; mie[k] = 0; mflag[k] = 0;
        for (int i = 0; i < 6; i++) begin mval[k][i] = 0; men[k][i] = 0; end
      end
      mpin = 0;
    end else begin
      pin_n = pin_sel ? !freq_in : ((mflag[0] && mie[0]) || (mflag[1] && mie[1]));
      for (int k = 0; k < 2; k++) begin
        bit any; bit ok; bit fire;
        any = 0; ok = 1;
        for (int i = 0; i < 6; i++)
          if (men[k][i]) begin
            any = 1;
            if (mval[k][i] != int'(tf[i])) ok = 0;
          end
        fire = tick && marm[k] && any && ok;
        mflag[k] = fire || (mflag[k] && !flag_clr[k]);
        if (fire && !mrep[k]) marm[k] = 0;
        if (cfg_we && int'(cfg_unit) == k) begin
          if (cfg_addr < 3'd6) begin
            mval[k][cfg_addr] = int'(cfg_wdata[7:0]);
            men[k][cfg_addr]  = cfg_wdata[8];
          end else if (cfg_addr == 3'd7) begin
            marm[k] = cfg_wdata[0]; mrep[k] = cfg_wdata[1]; mie[k] = cfg_wdata[2];
          end
        end
      end
      mpin = pin_n;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      tests++;
      if (flags != {mflag[1], mflag[0]} || armed != {marm[1], marm[0]} ||
          pin_drive_low != mpin) begin
        fails++;
        $display("FAIL R2/model cycle %0d: flags=%b armed=%b pin=%b exp flags=%b armed=%b pin=%b",
                 cycles, flags, armed, pin_drive_low, {mflag[1], mflag[0]},
                 {marm[1], marm[0]}, mpin);
      end
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int u, input int a, input int d);
    cfg_we = 1'b1; cfg_unit = 1'(u); cfg_addr = 3'(a); cfg_wdata = 9'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clr(input int u);
    flag_clr[u] = 1'b1;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) tf[i] = 8'd0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags", int'(flags), 0);
    chk("R1 armed", int'(armed), 0);
    chk("R1 pin", int'(pin_drive_low), 0);

    // unit 0: seconds = 5, one-shot, interrupt
    wr(0, 0, 9'h105);
    wr(0, 7, 3'b101);
    tf[0] = 8'd5;
    idle(3);
    chk("R2 no tick no fire", int'(flags[0]), 0);
    tk();
    chk("R2 fire on tick", int'(flags[0]), 1);
    chk("R5 disarm", int'(armed[0]), 0);
    chk("R8 pin lags", int'(pin_drive_low), 0);
    idle(1);
    chk("R8 pin low", int'(pin_drive_low), 1);
    clr(0);
    chk("R7 clear", int'(flags[0]), 0);
    idle(1);
    chk("R8 pin release", int'(pin_drive_low), 0);
    tk();
    chk("R5 no refire", int'(flags[0]), 0);

    // unit 1: sec 10, min 3, hour 7 disabled, repeat, polled
    wr(1, 0, 9'h10A);
    wr(1, 1, 9'h103);
    wr(1, 2, 9'h007);
    wr(1, 7, 3'b011);
    tf[0] = 8'd10; tf[1] = 8'd4; tf[2] = 8'd9;
    tk();
    chk("R3 enabled mismatch", int'(flags[1]), 0);
    tf[1] = 8'd3;
    tk();
    chk("R3 disabled ignored", int'(flags[1]), 1);
    chk("R6 stays armed", int'(armed[1]), 1);
    chk("R10 unit0 untouched", int'(flags[0]), 0);
    idle(1);
    chk("R8 polled pin", int'(pin_drive_low), 0);
    clr(1);
    tk();
    chk("R6 refire", int'(flags[1]), 1);

    flag_clr[1] = 1'b1; tick = 1'b1;
    @(negedge clk);
    flag_clr = 2'b00; tick = 1'b0;
    chk("R7 set wins", int'(flags[1]), 1);
    clr(1);
    chk("R7 cleared", int'(flags[1]), 0);

    // unit 0: no field enabled
    wr(0, 0, 9'h005);
    wr(0, 7, 3'b001);
    tk();
    tf[0] = 8'd5;
    tk();
    chk("R4 never fires", int'(flags[0]), 0);
    chk("R4 still armed", int'(armed[0]), 1);

    // unit 0: all six fields
    wr(0, 0, 9'h10A); wr(0, 1, 9'h103); wr(0, 2, 9'h109);
    wr(0, 3, 9'h102); wr(0, 4, 9'h10F); wr(0, 5, 9'h106);
    tf[0] = 8'd10; tf[1] = 8'd3; tf[2] = 8'd9; tf[3] = 8'd2; tf[4] = 8'd15; tf[5] = 8'd7;
    tk();
    chk("R3 month mismatch", int'(flags[0]), 0);
    tf[5] = 8'd6;
    tk();
    chk("R3 full match", int'(flags[0]), 1);
    chk("R5 disarm full", int'(armed[0]), 0);
    chk("R10 unit1 kept", int'(armed[1]), 1);

    // frequency mode
    wr(1, 7, 3'b111);
    pin_sel = 1'b1; freq_in = 1'b0;
    idle(1);
    chk("R9 freq low", int'(pin_drive_low), 1);
    freq_in = 1'b1;
    idle(1);
    chk("R9 freq high", int'(pin_drive_low), 0);
    tk();
    idle(1);
    chk("R9 flag ignored flag", int'(flags[1]), 1);
    chk("R9 flag ignored pin", int'(pin_drive_low), 0);
    pin_sel = 1'b0;
    idle(1);
    chk("R8 interrupt after freq", int'(pin_drive_low), 1);
    idle(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule